// File: doc/BRIEF.md
# Power-Mode and Watchdog Control Register

This block is an 8-bit control register for a small embedded processor core. It holds two general-purpose software flags and a load-enable bit that controls write access to a watchdog timer. It also holds two one-shot mode bits, idle and power-down, which drive request lines to a clock controller. The mode bits clear themselves when the condition that ends the mode arrives. An interrupt ends idle, and a wake event ends power-down.

A small down-counting watchdog sits next to the register. Software can load it only while the load-enable bit is set, and the first accepted load starts it. Once the watchdog runs, clearing load-enable does not stop it. Only a magic value written to a key location, or a hardware reset, halts it. When the count expires, the watchdog raises a one-cycle reset request and reloads itself.

The block sits on a simple internal register bus with address, write strobe, write data and a combinational read port. The address map is:

| Offset | Register | Read value |
|---|---|---|
| 0 | Mode register | Mode bits |
| 1 | Timer | Current count |
| 2 | Key | Write-only, reads 0 |
| 3 | Unused | Reads 0 |

Top module: `pwrwdt_ctrl`

## Requirements
- R1: After a synchronous hardware reset, every register is 0. This covers the mode register, the timer count, the reload value and the run state. Every request output is low.
- R2: The mode register has the following bit layout. Bits 7..5 are reserved: they read as 0 and writes to them are ignored.

  | Bit | Function |
  |---|---|
  | 4 | Watchdog load enable |
  | 3 | Flag B |
  | 2 | Flag A |
  | 1 | Power-down |
  | 0 | Idle |

- R3: Flags A and B store whatever software writes and affect no output.
- R4: A single write that sets both bit 1 and bit 0 enters power-down only. After that write, power-down reads 1 and idle reads 0.
- R5: `idle_req_o` reflects the idle bit. When `irq_i` is high, the idle bit is 0 from the next cycle on. This also holds when the same cycle writes idle as 1.
- R6: `pdown_req_o` reflects the power-down bit. When `wake_i` is high, the power-down bit is 0 from the next cycle on, even against a write of 1 in the same cycle. `irq_i` does not clear power-down.
- R7: A write to the timer at offset 1 while load enable is 1 has three effects. It loads both the count and the reload value with the write data. It raises `wdt_run_o`, and it takes priority over a tick in the same cycle.
- R8: A timer write while load enable is 0 is dropped. The count and the run state stay as they were.
- R9: While running, each cycle with `wdt_tick_i` high either decrements a count above 1 or handles expiry. A count of 1 or 0 expires: the count reloads and `wdt_rst_req_o` pulses high for exactly one cycle.
- R10: Writing 0x55 to the key at offset 2 stops a running watchdog and freezes its count, and it wins over a tick in the same cycle. Any other key value has no effect.
- R11: `wdt_load_en_o` follows mode bit 4. Clearing that bit does not stop a running watchdog.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| bus_addr | input | ADDR_W | Register offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| wake_i | input | 1 | Wake event, ends power-down |
| irq_i | input | 1 | Interrupt, ends idle |
| wdt_tick_i | input | 1 | Watchdog count enable |
| idle_req_o | output | 1 | Idle-mode request to the clock controller |
| pdown_req_o | output | 1 | Power-down request to the clock controller |
| wdt_load_en_o | output | 1 | Timer writes permitted |
| wdt_run_o | output | 1 | Watchdog is running |
| wdt_rst_req_o | output | 1 | One-cycle reset request on watchdog expiry |

## Verification
The bench writes 0xFF to the mode register to confirm that reserved bits are dropped. The same write checks the power-down-over-idle priority: a design without that priority would raise both clock requests at once. It races the wake and interrupt lines against writes that set the corresponding mode bit. A design that let the write win would leave the core stuck in a sleep mode. The bench also checks that a timer write with load enable cleared is dropped, and that clearing load enable leaves a running watchdog running. It checks that only 0x55, and not a nearby value, stops the count. Finally, it counts expiry pulses across a reload, so a design off by one tick or with a stretched pulse shows a wrong count.

// File: rtl/pwrwdt_pkg.sv
package pwrwdt_pkg;

    localparam int REG_W      = 8;
    localparam int OFS_MODE   = 0;
    localparam int OFS_TIMER  = 1;
    localparam int OFS_KEY    = 2;
    localparam logic [REG_W-1:0] WDT_STOP_KEY = 8'h55;

    // Software-visible mode bits, MSB first (bit 4 down to bit 0)
    typedef struct packed {
        logic load_en;
        logic flag_b;
        logic flag_a;
        logic pdown;
        logic idle;
    } mode_reg_t;

    typedef enum logic [1:0] {
        SEL_MODE  = 2'd0,
        SEL_TIMER = 2'd1,
        SEL_KEY   = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_t;

    // Turn a write value into register contents; power-down beats idle
    function automatic mode_reg_t mode_from_write(input logic [4:0] wv);
        mode_reg_t m;
        m = mode_reg_t'(wv);
        if (m.pdown) m.idle = 1'b0;
        return m;
    endfunction

    function automatic logic [REG_W-1:0] mode_to_byte(input mode_reg_t m);
        return {3'b000, m};
    endfunction

endpackage

// File: rtl/pwrwdt_decode.sv
module pwrwdt_decode
    import pwrwdt_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    output reg_sel_t          sel,
    output logic              wr_mode,
    output logic              wr_timer,
    output logic              wr_key
);

    always_comb begin
        if (addr == ADDR_W'(OFS_MODE))       sel = SEL_MODE;
        else if (addr == ADDR_W'(OFS_TIMER)) sel = SEL_TIMER;
        else if (addr == ADDR_W'(OFS_KEY))   sel = SEL_KEY;
        else                                 sel = SEL_NONE;
    end

    assign wr_mode  = we && (sel == SEL_MODE);
    assign wr_timer = we && (sel == SEL_TIMER);
    assign wr_key   = we && (sel == SEL_KEY);

endmodule

// File: rtl/pwrwdt_mode.sv
module pwrwdt_mode
    import pwrwdt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr,
    input  logic [4:0] wdata,
    input  logic       wake,
    input  logic       irq,
    output mode_reg_t  mode
);

    mode_reg_t mode_q, mode_d;

    always_comb begin
        mode_d = mode_q;
        if (wr) mode_d = mode_from_write(wdata);
        // exit events override a simultaneous write
        if (irq)  mode_d.idle  = 1'b0;
        if (wake) mode_d.pdown = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) mode_q <= '0;
        else     mode_q <= mode_d;
    end

    assign mode = mode_q;

    // R4
    mode_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(mode_q.pdown && mode_q.idle));

    // R5
    irq_clear_chk: assert property (@(posedge clk) disable iff (rst)
        irq |=> !mode_q.idle);

    // R6
    wake_clear_chk: assert property (@(posedge clk) disable iff (rst)
        wake |=> !mode_q.pdown);

    // R6
    irq_keeps_pd_chk: assert property (@(posedge clk) disable iff (rst)
        (irq && !wake && !wr && mode_q.pdown) |=> mode_q.pdown);

endmodule

// File: rtl/pwrwdt_timer.sv
module pwrwdt_timer
    import pwrwdt_pkg::*;
#(
    parameter int WDT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_en,
    input  logic             wr_timer,
    input  logic             wr_key,
    input  logic [REG_W-1:0] wdata,
    input  logic             tick,
    output logic [WDT_W-1:0] count,
    output logic             run,
    output logic             rst_req
);

    logic [WDT_W-1:0] cnt_q, cnt_d, rld_q, rld_d, load_val;
    logic             run_q, run_d, req_q, req_d, expire, stop;

    assign load_val = WDT_W'(wdata);
    assign expire   = run_q && tick && (cnt_q <= WDT_W'(1));
    assign stop     = wr_key && (wdata == WDT_STOP_KEY);

    always_comb begin
        cnt_d = cnt_q;
        rld_d = rld_q;
        run_d = run_q;
        req_d = 1'b0;
        if (run_q && tick) begin
            if (expire) begin
                cnt_d = rld_q;
                req_d = 1'b1;
            end else begin
                cnt_d = cnt_q - WDT_W'(1);
            end
        end
        if (wr_timer && load_en) begin
            cnt_d = load_val;
            rld_d = load_val;
            run_d = 1'b1;
            req_d = 1'b0;
        end
        if (stop) begin
            cnt_d = cnt_q;
            run_d = 1'b0;
            req_d = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            rld_q <= '0;
            run_q <= 1'b0;
            req_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            rld_q <= rld_d;
            run_q <= run_d;
            req_q <= req_d;
        end
    end

    assign count   = cnt_q;
    assign run     = run_q;
    assign rst_req = req_q;

    // R7
    load_start_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_timer && load_en) |=> (run_q && cnt_q == $past(load_val)));

    // R8
    drop_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_timer && !load_en && !(run_q && tick)) |=> (cnt_q == $past(cnt_q) && run_q == $past(run_q)));

    // R9
    req_source_chk: assert property (@(posedge clk) disable iff (rst)
        req_q |-> $past(run_q && tick));

    // R10
    key_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_key && wdata == WDT_STOP_KEY) |=> (!run_q && !req_q));

    // R11
    run_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (run_q && !wr_key) |=> run_q);

endmodule

// File: rtl/pwrwdt_ctrl.sv
module pwrwdt_ctrl
    import pwrwdt_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int WDT_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              wake_i,
    input  logic              irq_i,
    input  logic              wdt_tick_i,
    output logic              idle_req_o,
    output logic              pdown_req_o,
    output logic              wdt_load_en_o,
    output logic              wdt_run_o,
    output logic              wdt_rst_req_o
);

    reg_sel_t         sel;
    logic             wr_mode, wr_timer, wr_key;
    mode_reg_t        mode;
    logic [WDT_W-1:0] count;

    pwrwdt_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr     (bus_addr),
        .we       (bus_we),
        .sel      (sel),
        .wr_mode  (wr_mode),
        .wr_timer (wr_timer),
        .wr_key   (wr_key)
    );

    pwrwdt_mode u_mode (
        .clk   (clk),
        .rst   (rst),
        .wr    (wr_mode),
        .wdata (bus_wdata[4:0]),
        .wake  (wake_i),
        .irq   (irq_i),
        .mode  (mode)
    );

    pwrwdt_timer #(.WDT_W(WDT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load_en  (mode.load_en),
        .wr_timer (wr_timer),
        .wr_key   (wr_key),
        .wdata    (bus_wdata),
        .tick     (wdt_tick_i),
        .count    (count),
        .run      (wdt_run_o),
        .rst_req  (wdt_rst_req_o)
    );

    always_comb begin
        case (sel)
            SEL_MODE:  bus_rdata = mode_to_byte(mode);
            SEL_TIMER: bus_rdata = REG_W'(count);
            default:   bus_rdata = '0;
        endcase
    end

    assign idle_req_o    = mode.idle;
    assign pdown_req_o   = mode.pdown;
    assign wdt_load_en_o = mode.load_en;

    // R2
    reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (sel == SEL_MODE) |-> (bus_rdata[7:5] == 3'b000));

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> !(idle_req_o || pdown_req_o || wdt_run_o || wdt_rst_req_o || wdt_load_en_o));

endmodule

// File: tb/tb_pwrwdt_ctrl.sv
`timescale 1ns/1ps
module tb_pwrwdt_ctrl;

    localparam int ADDR_W = 2;
    localparam int K_READ = 0, K_STAT = 1, K_PULSE = 2;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_we = 1'b0;
    logic [7:0]        bus_wdata = '0;
    logic [7:0]        bus_rdata;
    logic              wake_i = 1'b0, irq_i = 1'b0, wdt_tick_i = 1'b0;
    logic              idle_req_o, pdown_req_o, wdt_load_en_o, wdt_run_o, wdt_rst_req_o;

    int    checks = 0, failures = 0, pulses = 0;
    bit    probe = 1'b0, done = 1'b0;
    int    kind_q[$], exp_q[$];
    string tag_q[$];

    always #10 clk = ~clk;

    pwrwdt_ctrl #(.ADDR_W(ADDR_W), .WDT_W(8)) dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wake_i(wake_i),
        .irq_i(irq_i), .wdt_tick_i(wdt_tick_i), .idle_req_o(idle_req_o),
        .pdown_req_o(pdown_req_o), .wdt_load_en_o(wdt_load_en_o),
        .wdt_run_o(wdt_run_o), .wdt_rst_req_o(wdt_rst_req_o)
    );

    // count expiry pulses, sampled mid-cycle
    always @(negedge clk) if (!rst && wdt_rst_req_o) pulses++;

    // monitor: pops expected items and compares
    initial forever begin
        @(posedge clk);
        #2;
        if (probe && kind_q.size() > 0) begin
            automatic int    k = kind_q.pop_front();
            automatic int    e = exp_q.pop_front();
            automatic string t = tag_q.pop_front();
            automatic int    obs;
            if (k == K_READ)      obs = int'(bus_rdata);
            else if (k == K_STAT) obs = int'({wdt_load_en_o, wdt_run_o, pdown_req_o, idle_req_o});
            else                  obs = pulses;
            checks++;
            if (obs != e) begin
                failures++;
                $display("FAIL %s kind=%0d actual=0x%0h expected=0x%0h", t, k, obs, e);
            end
        end
    end

    // driver tasks
    task automatic expect_item(input int k, input int a, input int e, input string t);
        @(negedge clk);
        kind_q.push_back(k); exp_q.push_back(e); tag_q.push_back(t);
        bus_addr = ADDR_W'(a);
        probe = 1'b1;
        @(negedge clk);
        probe = 1'b0;
    endtask

    task automatic rd(input int a, input int e, input string t);
        expect_item(K_READ, a, e, t);
    endtask

    // status = {load_en, run, pdown, idle}
    task automatic stat(input int e, input string t);
        expect_item(K_STAT, 0, e, t);
    endtask

    task automatic wr(input int a, input int d, input bit wk, input bit iq);
        @(negedge clk);
        bus_addr = ADDR_W'(a); bus_wdata = 8'(d); bus_we = 1'b1;
        wake_i = wk; irq_i = iq;
        @(negedge clk);
        bus_we = 1'b0; wake_i = 1'b0; irq_i = 1'b0;
    endtask

    task automatic pulse_in(input bit wk, input bit iq);
        @(negedge clk);
        wake_i = wk; irq_i = iq;
        @(negedge clk);
        wake_i = 1'b0; irq_i = 1'b0;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        wdt_tick_i = 1'b1;
        repeat (n) @(negedge clk);
        wdt_tick_i = 1'b0;
    endtask

    task automatic hw_reset();
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        rd(0, 8'h00, "R1 mode after reset");
        rd(1, 8'h00, "R1 timer after reset");
        stat(4'b0000, "R1 outputs after reset");

        // R2 reserved dropped, R4 pdown beats idle
        wr(0, 8'hFF, 0, 0);
        rd(0, 8'h1E, "R2 R4 write 0xFF");
        stat(4'b1010, "R4 only pdown requested");

        // R3 flags are plain storage
        wr(0, 8'h0C, 0, 0);
        rd(0, 8'h0C, "R3 flags read back");
        stat(4'b0000, "R3 flags drive nothing");

        // R5 idle and interrupt exit
        wr(0, 8'h01, 0, 0);
        stat(4'b0001, "R5 idle requested");
        pulse_in(0, 1);
        rd(0, 8'h00, "R5 irq clears idle");
        wr(0, 8'h01, 0, 1);
        stat(4'b0000, "R5 irq beats same-cycle write");

        // R6 power-down and wake
        wr(0, 8'h02, 0, 0);
        pulse_in(0, 1);
        stat(4'b0010, "R6 irq leaves pdown");
        pulse_in(1, 0);
        stat(4'b0000, "R6 wake clears pdown");
        wr(0, 8'h02, 1, 0);
        rd(0, 8'h00, "R6 wake beats same-cycle write");

        // R8 timer write with load enable clear
        wr(1, 8'h05, 0, 0);
        rd(1, 8'h00, "R8 locked write dropped");
        stat(4'b0000, "R8 not started");

        // R7 load and start, R9 countdown
        wr(0, 8'h10, 0, 0);
        wr(1, 8'h03, 0, 0);
        stat(4'b1100, "R7 running after load");
        rd(1, 8'h03, "R7 count loaded");
        ticks(2);
        rd(1, 8'h01, "R9 two ticks");
        expect_item(K_PULSE, 0, 0, "R9 no pulse yet");
        ticks(1);
        expect_item(K_PULSE, 0, 1, "R9 single expiry pulse");
        rd(1, 8'h03, "R9 reload after expiry");

        // R11 clearing load enable keeps it running; R8 write dropped
        wr(0, 8'h00, 0, 0);
        stat(4'b0100, "R11 still running");
        wr(1, 8'h09, 0, 0);
        rd(1, 8'h03, "R8 write dropped while running");

        // R10 key
        wr(2, 8'h54, 0, 0);
        stat(4'b0100, "R10 wrong key ignored");
        wr(2, 8'h55, 0, 0);
        stat(4'b0000, "R10 key stops");
        ticks(4);
        rd(1, 8'h03, "R10 count frozen");
        expect_item(K_PULSE, 0, 1, "R10 no pulse when stopped");
        rd(2, 8'h00, "R2 key reads zero");
        rd(3, 8'h00, "R2 unused offset reads zero");

        // R1 hardware reset stops the watchdog
        wr(0, 8'h10, 0, 0);
        wr(1, 8'h02, 0, 0);
        stat(4'b1100, "R7 restart");
        hw_reset();
        stat(4'b0000, "R1 reset stops watchdog");
        rd(1, 8'h00, "R1 count cleared");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog timeout actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule